// File: doc/BRIEF.md
# Bidirectional GPIO Port with Grouped Pulldowns

This block controls an 8-bit general-purpose I/O port through a small register bus. Software holds an output value in a data latch and chooses, pin by pin, whether each pin drives or listens through a direction register. The block drives per-pin output enables and output values towards the pads. It samples the pad levels through a two-stage synchronizer.

A read of the data offset returns a mix of two sources. Output pins return the latch contents. Input pins return the synchronized pad level.

Each pin also gets a pulldown enable. A write-only control register holds one active-low bit per four-pin group. A pulldown is on only for an input pin whose group bit is clear, and only while the global option input allows software pulldowns. After reset every pin is an input and every pulldown is requested.

Top module: `gpio_pd_port`

## Requirements
- R1: After reset the latch, the direction register and both pulldown group bits are zero. Then `pad_oe` = 0x00 and `pad_out` = 0x00, and `pad_pd_en` = 0xFF while `pull_en_global` is 1.
- R2: A write with `bus_addr` = 1 loads the direction register from `bus_wdata`, and the register is visible from the next cycle. `pad_oe[i]` = 1 (output) exactly when direction bit i is 1, and a read at address 1 returns the register.
- R3: A write with `bus_addr` = 0 loads the data latch whatever the direction bits hold. `pad_out` always equals the latch, so a value written while a pin is an input appears once that pin becomes an output.
- R4: A read at address 0 returns, for each bit i, the latch bit when direction bit i is 1 and the synchronized pad bit when it is 0.
- R5: A change on `pad_in` reaches the address-0 read data after exactly two rising clock edges. After one edge the read data still shows the old level.
- R6: A write with `bus_addr` = 2 loads the group bits. `bus_wdata[0]` governs pins 3..0 and `bus_wdata[1]` governs pins 7..4. A cleared group bit turns on the pulldowns of the input pins in its group, and a set group bit turns them off.
- R7: A pin whose direction bit is 1 never has `pad_pd_en` asserted, whatever the group bits hold.
- R8: While `pull_en_global` is 0, `pad_pd_en` is 0x00.
- R9: Reads at address 2 (write-only) and address 3 (unused) return 0x00. Writes to address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 pulldown groups |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Output values towards the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pull_en_global | input | 1 | Global permission for software pulldowns |
| pad_pd_en | output | 8 | Per-pin pulldown enable |

## Verification
The hardest case to reach from the ports is a latch value written while its pin is an input. It leaves no trace at the read port until the direction changes. The stimulus writes the latch with all pins as inputs, and first confirms that the read data follows the pads rather than the latch. It then switches the direction and expects the earlier value. Random rounds mix writes to every offset, including the unused one, with pad changes and toggles of the global enable. Each check waits until the pads have settled through the synchronizer. A directed step then measures the two-edge latency against an edge that should still show the old level.

// File: rtl/gpio_pd_pkg.sv
// Package: shared register-select encoding for the GPIO port.
// Assumes a 2-bit register address; offset 3 is unused.
package gpio_pd_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PDG  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_pd_regs.sv
// Module: holds the data latch, the direction register and the
// pulldown group bits. Assumes single-cycle writes qualified by wr_en.
// Writes to unused offsets are dropped.
module gpio_pd_regs
    import gpio_pd_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int NGROUPS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  lat_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [NGROUPS-1:0] pdg_q
);
    // Register update: synchronous reset clears everything, then one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
            dir_q <= '0;
            pdg_q <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                SEL_DATA: lat_q <= wr_data;
                SEL_DIR:  dir_q <= wr_data;
                SEL_PDG:  pdg_q <= wr_data[NGROUPS-1:0];
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pd_sync.sv
// Module: multi-stage synchronizer for the pad inputs.
// Assumes pad_in is asynchronous. Its latency equals STAGES edges.
module gpio_pd_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw pad levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= async_in;
                end
            end else begin : g_next
                // Later stage: resample the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/gpio_pd_pull.sv
// Module: per-pin pulldown gating. Assumes active-low group bits, with
// GROUP_W pins per group, and suppresses pulldowns on output pins.
module gpio_pd_pull #(
    parameter int WIDTH   = 8,
    parameter int GROUP_W = 4,
    localparam int NGROUPS = WIDTH / GROUP_W
) (
    input  logic               glob_en,
    input  logic [WIDTH-1:0]   dir_q,
    input  logic [NGROUPS-1:0] pdg_q,
    output logic [WIDTH-1:0]   pd_en
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pin
            // Pulldown on only for an input pin with its group bit clear.
            assign pd_en[i] = glob_en & ~dir_q[i] & ~pdg_q[i / GROUP_W];
        end
    endgenerate
endmodule

// File: rtl/gpio_pd_port.sv
// Module: top of the GPIO port. Ties the registers, the pad synchronizer
// and the pulldown gating together, and muxes the read data.
// Assumes WIDTH is a multiple of GROUP_W.
module gpio_pd_port
    import gpio_pd_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int GROUP_W     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    input  logic              pull_en_global,
    output logic [WIDTH-1:0]  pad_pd_en
);
    localparam int NGROUPS = WIDTH / GROUP_W;

    logic [WIDTH-1:0]   lat_q;
    logic [WIDTH-1:0]   dir_q;
    logic [NGROUPS-1:0] pdg_q;
    logic [WIDTH-1:0]   pin_s;

    gpio_pd_regs #(.WIDTH(WIDTH), .NGROUPS(NGROUPS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .lat_q   (lat_q),
        .dir_q   (dir_q),
        .pdg_q   (pdg_q)
    );

    gpio_pd_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_s)
    );

    gpio_pd_pull #(.WIDTH(WIDTH), .GROUP_W(GROUP_W)) u_pull (
        .glob_en (pull_en_global),
        .dir_q   (dir_q),
        .pdg_q   (pdg_q),
        .pd_en   (pad_pd_en)
    );

    assign pad_out = lat_q;
    assign pad_oe  = dir_q;

    // Read mux: the data offset picks latch or pad per bit; write-only and unused offsets read zero.
    always_comb begin
        case (reg_sel_e'(bus_addr))
            SEL_DATA: bus_rdata = (dir_q & lat_q) | (~dir_q & pin_s);
            SEL_DIR:  bus_rdata = dir_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pd_port_chk.sv
// Module: assertion checker for gpio_pd_port, attached by bind.
// Observes only the top-level ports.
module gpio_pd_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_addr,
    input logic             bus_wr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe,
    input logic             pull_en_global,
    input logic [WIDTH-1:0] pad_pd_en
);
    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> pad_oe == $past(bus_wdata));

    assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 2'd1) |=> $stable(pad_oe));

    assert_latch_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> pad_out == $past(bus_wdata));

    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 2'd0) |=> $stable(pad_out));

    assert_no_pd_on_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pd_en) == '0);

    assert_global_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pull_en_global |-> pad_pd_en == '0);

    assert_wo_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[1] |-> bus_rdata == '0);
endmodule

bind gpio_pd_port gpio_pd_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_wr         (bus_wr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .pad_out        (pad_out),
    .pad_oe         (pad_oe),
    .pull_en_global (pull_en_global),
    .pad_pd_en      (pad_pd_en)
);

// File: tb/gpio_pd_port_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random rounds against a bench model.
module gpio_pd_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic       pull_en_global = 1'b1;
    logic [7:0] pad_pd_en;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model of the registers
    logic [7:0] m_lat = 8'h00;
    logic [7:0] m_dir = 8'h00;
    logic [1:0] m_pdg = 2'b00;

    always #2 clk = ~clk;

    gpio_pd_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pull_en_global(pull_en_global),
        .pad_pd_en(pad_pd_en)
    );

    function automatic logic [7:0] exp_pd(input logic g, input logic [7:0] d, input logic [1:0] p);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = g & ~d[i] & ~p[i/4];
        return r;
    endfunction

    function automatic logic [7:0] exp_port(input logic [7:0] d, input logic [7:0] l, input logic [7:0] pin);
        return (d & l) | (~d & pin);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            2'd0: m_lat = d;
            2'd1: m_dir = d;
            2'd2: m_pdg = d[1:0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        check({tag, " R2 oe"}, pad_oe, m_dir);
        check({tag, " R3 out"}, pad_out, m_lat);
        check({tag, " R6 pd"}, pad_pd_en, exp_pd(pull_en_global, m_dir, m_pdg));
        rd(2'd0, v); check({tag, " R4 port"}, v, exp_port(m_dir, m_lat, pad_in));
        rd(2'd1, v); check({tag, " R2 dir rd"}, v, m_dir);
        rd(2'd2, v); check({tag, " R9 wo rd"}, v, 8'h00);
        rd(2'd3, v); check({tag, " R9 unused rd"}, v, 8'h00);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 oe", pad_oe, 8'h00);
        check("R1 out", pad_out, 8'h00);
        check("R1 pd", pad_pd_en, 8'hFF);

        // R8 global off
        pull_en_global = 1'b0; #0.5;
        check("R8 pd off", pad_pd_en, 8'h00);
        pull_en_global = 1'b1;

        // R6 group mapping: bit0 low nibble, bit1 high nibble
        wr(2'd2, 8'h01); #0.5; check("R6 low group off", pad_pd_en, 8'hF0);
        wr(2'd2, 8'h02); #0.5; check("R6 high group off", pad_pd_en, 8'h0F);
        wr(2'd2, 8'h00);

        // R7 output pins lose pulldown
        wr(2'd1, 8'h81); #0.5; check("R7 out pins pd", pad_pd_en, 8'h7E);
        wr(2'd1, 8'h00);

        // R3/R4 latch written while input: read follows pad, then latch
        pad_in = 8'hC3; settle();
        wr(2'd0, 8'h3C);
        check("R3 out while input", pad_out, 8'h3C);
        rd(2'd0, v); check("R4 input reads pad", v, 8'hC3);
        wr(2'd1, 8'hFF);
        rd(2'd0, v); check("R3 latch appears as output", v, 8'h3C);
        wr(2'd1, 8'h0F);
        rd(2'd0, v); check("R4 mixed", v, 8'hCC);

        // R9 write to unused offset changes nothing
        wr(2'd3, 8'hA5);
        check_all("R9 after unused wr");

        // R5 latency
        wr(2'd1, 8'h00);
        pad_in = 8'h00; settle();
        @(negedge clk); pad_in = 8'h5A;
        @(negedge clk); rd(2'd0, v); check("R5 one edge old", v, 8'h00);
        @(negedge clk); rd(2'd0, v); check("R5 two edges new", v, 8'h5A);

        // random rounds
        for (int n = 0; n < 300; n++) begin
            logic [1:0] a;
            a = 2'($urandom_range(0, 3));
            wr(a, 8'($urandom));
            pad_in = 8'($urandom);
            pull_en_global = 1'($urandom);
            settle();
            check_all("rand");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule